// File: doc/BRIEF.md
# Qualified Sample Droop Monitor

This block watches a digitised supply and tells downstream logic when that supply has sagged by about three percent since the last power cycle. A second input carries a comparator flag that reads 1 while the secondary winding sits below its detection level. When that flag stays high for a programmable number of clocks, the monitor arms. When the winding later returns above the level, the monitor issues a one-clock power-cycle strobe.

Each strobe freezes the newest supply code as a reference scaled to 993/1024 of its value. From then on, every fresh supply sample is compared with that reference. A sample at or below the reference raises the droop flag. Shorter low excursions on the winding do not count as power cycles and leave the reference alone.

An undervoltage lockout with hysteresis, working on the supply codes, holds the whole block idle until the supply is high enough. The default thresholds are set for 12-bit codes and a 10 MHz core clock.

Top module: `droop_mon_top`

## Requirements
- R1: Out of synchronous reset, enabled_o, pcd_o, droop_o and ref_o all read 0.
- R2: The block enables one clock after a valid sample whose code is at least UVLO_ON_CODE (default 1365). While it is disabled, no strobe is issued and ref_o stays 0, whatever the winding flag does.
- R3: Once enabled, the block stays enabled for samples down to UVLO_OFF_CODE (default 1280). A valid sample below UVLO_OFF_CODE disables it. Within two clocks after that, ref_o reads 0 and droop_o reads 0.
- R4: wind_low_i (1 = winding below threshold) passes through a two-flop synchroniser. A synchronised high run of at least QUAL_CYC clocks (default 5) arms the detector. The first synchronised low after that run yields exactly one pcd_o pulse, one clock wide.
- R5: A high run on wind_low_i shorter than QUAL_CYC clocks yields no pcd_o pulse. ref_o keeps its value.
- R6: One clock after a pcd_o pulse, ref_o equals floor(S*993/1024), where S is the most recent valid sample code.
- R7: One clock after each valid sample, droop_o is 1 if the sample code is at or below ref_o, and 0 if it is above.
- R8: droop_o stays 0 until the first strobe has loaded a reference. Each later strobe clears droop_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wind_low_i | input | 1 | Asynchronous comparator flag, 1 while the winding is below threshold |
| smp_valid_i | input | 1 | Qualifies smp_code_i for one clock |
| smp_code_i | input | ADC_W | Unsigned supply code from the ADC |
| enabled_o | output | 1 | Undervoltage lockout released |
| pcd_o | output | 1 | One-clock power-cycle strobe |
| ref_o | output | ADC_W | Stored droop reference |
| droop_o | output | 1 | Latest sample at or below the reference |

## Verification
The bench builds the block with its default parameters: 12-bit codes, a qualifying count of 5, and lockout thresholds of 1365 and 1280.

With QUAL_CYC at 5, winding runs of 4 and 5 clocks sit on either side of the arming boundary. A run of 4 must be ignored and a run of 5 must produce a strobe. Supply codes 1939 and 1940 straddle the scaled reference derived from 2000. The codes 1364 and 1365 straddle the turn-on threshold, and 1300 and 1270 fall on either side of the turn-off threshold.

// File: rtl/dm_pkg.sv
package dm_pkg;

  typedef enum logic [1:0] {
    PCD_IDLE  = 2'd0,
    PCD_COUNT = 2'd1,
    PCD_ARMED = 2'd2
  } pcd_state_t;

endpackage

// File: rtl/dm_sync.sv
module dm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/dm_uvlo.sv
module dm_uvlo #(
  parameter int ADC_W        = 12,
  parameter int UVLO_ON_CODE  = 1365,
  parameter int UVLO_OFF_CODE = 1280
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_valid_i,
  input  logic [ADC_W-1:0] smp_code_i,
  output logic             en_o
);

  localparam logic [ADC_W-1:0] ON_C  = ADC_W'(UVLO_ON_CODE);
  localparam logic [ADC_W-1:0] OFF_C = ADC_W'(UVLO_OFF_CODE);

  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
    end else if (smp_valid_i) begin
      if (!en_q && smp_code_i >= ON_C)      en_q <= 1'b1;
      else if (en_q && smp_code_i < OFF_C)  en_q <= 1'b0;
    end
  end

  assign en_o = en_q;

  AST_UVLO_HOLD_ON: assert property (@(posedge clk) disable iff (rst)
    (en_q && smp_valid_i && smp_code_i >= OFF_C) |=> en_q); // R3
  AST_UVLO_STAY_OFF: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !smp_valid_i) |=> !en_q); // R2

endmodule

// File: rtl/dm_pcd.sv
module dm_pcd
  import dm_pkg::*;
#(
  parameter int QUAL_CYC = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic low_i,
  output logic pcd_o
);

  localparam int CNT_W = $clog2(QUAL_CYC + 1);
  localparam logic [CNT_W-1:0] QUAL_C = CNT_W'(QUAL_CYC);
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

  pcd_state_t       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pcd_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      st_q  <= PCD_IDLE;
      cnt_q <= '0;
      pcd_q <= 1'b0;
    end else begin
      pcd_q <= 1'b0;
      case (st_q)
        PCD_IDLE: begin
          if (low_i) begin
            cnt_q <= ONE_C;
            st_q  <= (ONE_C >= QUAL_C) ? PCD_ARMED : PCD_COUNT;
          end
        end
        PCD_COUNT: begin
          if (!low_i) begin
            cnt_q <= '0;
            st_q  <= PCD_IDLE;
          end else begin
            cnt_q <= cnt_q + ONE_C;
            if (cnt_q + ONE_C >= QUAL_C) st_q <= PCD_ARMED;
          end
        end
        PCD_ARMED: begin
          if (!low_i) begin
            pcd_q <= 1'b1;
            cnt_q <= '0;
            st_q  <= PCD_IDLE;
          end
        end
        default: begin
          cnt_q <= '0;
          st_q  <= PCD_IDLE;
        end
      endcase
    end
  end

  assign pcd_o = pcd_q;

  AST_PCD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pcd_q |=> !pcd_q); // R4
  AST_PCD_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
    pcd_q |-> $past(st_q) == PCD_ARMED); // R5
  AST_PCD_GATED: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !pcd_q); // R2

endmodule

// File: rtl/dm_ref.sv
module dm_ref #(
  parameter int ADC_W       = 12,
  parameter int SCALE_NUM   = 993,
  parameter int SCALE_SHIFT = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             pcd_i,
  input  logic             smp_valid_i,
  input  logic [ADC_W-1:0] smp_code_i,
  output logic [ADC_W-1:0] ref_o,
  output logic             droop_o
);

  localparam int PROD_W = ADC_W + SCALE_SHIFT;
  localparam logic [PROD_W-1:0] NUM_C = PROD_W'(SCALE_NUM);

  logic [ADC_W-1:0]  last_q;
  logic [ADC_W-1:0]  ref_q;
  logic              ref_ok_q;
  logic              droop_q;
  logic [PROD_W-1:0] prod;
  logic [ADC_W-1:0]  scaled;

  always_comb begin
    prod   = PROD_W'(last_q) * NUM_C;
    scaled = prod[SCALE_SHIFT +: ADC_W];
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= '0;
    else if (smp_valid_i) last_q <= smp_code_i;
  end

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      ref_q    <= '0;
      ref_ok_q <= 1'b0;
      droop_q  <= 1'b0;
    end else if (pcd_i) begin
      ref_q    <= scaled;
      ref_ok_q <= 1'b1;
      droop_q  <= 1'b0;
    end else if (smp_valid_i && ref_ok_q) begin
      droop_q  <= (smp_code_i <= ref_q);
    end
  end

  assign ref_o   = ref_q;
  assign droop_o = droop_q;

  AST_REF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (en_i && !pcd_i) |=> ref_q == $past(ref_q)); // R5
  AST_REF_BELOW_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    (en_i && pcd_i) |=> ref_q <= $past(last_q)); // R6
  AST_DROOP_NEEDS_REF: assert property (@(posedge clk) disable iff (rst)
    droop_q |-> ref_ok_q); // R8
  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (ref_q == '0 && !droop_q)); // R3

endmodule

// File: rtl/droop_mon_top.sv
module droop_mon_top #(
  parameter int ADC_W         = 12,
  parameter int QUAL_CYC      = 5,
  parameter int SCALE_NUM     = 993,
  parameter int SCALE_SHIFT   = 10,
  parameter int UVLO_ON_CODE  = 1365,
  parameter int UVLO_OFF_CODE = 1280,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wind_low_i,
  input  logic             smp_valid_i,
  input  logic [ADC_W-1:0] smp_code_i,
  output logic             enabled_o,
  output logic             pcd_o,
  output logic [ADC_W-1:0] ref_o,
  output logic             droop_o
);

  logic en_w;
  logic low_sync_w;
  logic pcd_w;

  dm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(wind_low_i), .sync_o(low_sync_w)
  );

  dm_uvlo #(
    .ADC_W(ADC_W), .UVLO_ON_CODE(UVLO_ON_CODE), .UVLO_OFF_CODE(UVLO_OFF_CODE)
  ) u_uvlo (
    .clk(clk), .rst(rst), .smp_valid_i(smp_valid_i),
    .smp_code_i(smp_code_i), .en_o(en_w)
  );

  dm_pcd #(.QUAL_CYC(QUAL_CYC)) u_pcd (
    .clk(clk), .rst(rst), .en_i(en_w), .low_i(low_sync_w), .pcd_o(pcd_w)
  );

  dm_ref #(
    .ADC_W(ADC_W), .SCALE_NUM(SCALE_NUM), .SCALE_SHIFT(SCALE_SHIFT)
  ) u_ref (
    .clk(clk), .rst(rst), .en_i(en_w), .pcd_i(pcd_w),
    .smp_valid_i(smp_valid_i), .smp_code_i(smp_code_i),
    .ref_o(ref_o), .droop_o(droop_o)
  );

  assign enabled_o = en_w;
  assign pcd_o     = pcd_w;

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!enabled_o && !pcd_o && !droop_o && ref_o == '0)); // R1

endmodule

// File: tb/droop_mon_top_tb.sv
module droop_mon_top_tb_top;

  localparam int ADC_W = 12;
  localparam int QUAL  = 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wind_low_i = 1'b0;
  logic             smp_valid_i = 1'b0;
  logic [ADC_W-1:0] smp_code_i = '0;
  logic             enabled_o, pcd_o, droop_o;
  logic [ADC_W-1:0] ref_o;

  int n_run  = 0;
  int n_fail = 0;
  int exp_q[$];
  int last_smp = 0;
  bit exp_en = 0;
  bit pend = 0;
  int pend_val = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  droop_mon_top dut_i (
    .clk(clk), .rst(rst), .wind_low_i(wind_low_i), .smp_valid_i(smp_valid_i),
    .smp_code_i(smp_code_i), .enabled_o(enabled_o), .pcd_o(pcd_o),
    .ref_o(ref_o), .droop_o(droop_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Scoreboard monitor: each strobe pops one expected reference (R4, R6)
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (pend) begin
        check("R6 ref after strobe", int'(ref_o), pend_val);
        pend = 0;
      end
      if (pcd_o) begin
        if (exp_q.size() == 0) begin
          check("R5 unexpected strobe", 1, 0);
        end else begin
          pend_val = exp_q.pop_front();
          pend = 1;
        end
      end
    end
  end

  task automatic drive_sample(input int code);
    @(posedge clk); #1;
    smp_valid_i = 1'b1;
    smp_code_i  = ADC_W'(code);
    last_smp    = code;
    @(posedge clk); #1;
    smp_valid_i = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input int len);
    @(posedge clk); #1;
    wind_low_i = 1'b1;
    if (len >= QUAL && exp_en) exp_q.push_back((last_smp * 993) >> 10);
    repeat (len) @(posedge clk);
    #1;
    wind_low_i = 1'b0;
    repeat (8) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset values
    check("R1 enabled", int'(enabled_o), 0);
    check("R1 pcd", int'(pcd_o), 0);
    check("R1 droop", int'(droop_o), 0);
    check("R1 ref", int'(ref_o), 0);
    @(posedge clk); #1;
    rst = 1'b0;

    // R2 below turn-on: stays off, pulses ignored
    drive_sample(1000);
    check("R2 off below on", int'(enabled_o), 0);
    pulse(8);
    check("R2 ref held at zero", int'(ref_o), 0);
    drive_sample(1364);
    check("R2 1364 stays off", int'(enabled_o), 0);
    drive_sample(1365);
    exp_en = 1;
    check("R2 1365 enables", int'(enabled_o), 1);

    // R3 hysteresis and R8 no droop before a reference
    drive_sample(1300);
    check("R3 hysteresis keeps on", int'(enabled_o), 1);
    check("R8 no droop without ref", int'(droop_o), 0);

    // R4 qualifying pulse loads a reference
    drive_sample(2000);
    pulse(QUAL);
    check("R6 ref 2000", int'(ref_o), 1939);

    // R5 short pulse ignored
    pulse(QUAL - 1);
    check("R5 ref unchanged", int'(ref_o), 1939);
    pulse(1);
    check("R5 ref unchanged 1", int'(ref_o), 1939);

    // R7 comparison boundary
    drive_sample(1940);
    check("R7 above ref", int'(droop_o), 0);
    drive_sample(1939);
    check("R7 equal ref", int'(droop_o), 1);
    drive_sample(1800);
    check("R7 below ref", int'(droop_o), 1);

    // R8 strobe clears droop, R6 new reference
    pulse(QUAL + 3);
    check("R8 strobe clears droop", int'(droop_o), 0);
    check("R6 ref 1800", int'(ref_o), 1745);
    drive_sample(1746);
    check("R7 above new ref", int'(droop_o), 0);

    // R3 turn-off clears state
    drive_sample(1270);
    exp_en = 0;
    check("R3 disabled", int'(enabled_o), 0);
    check("R3 ref cleared", int'(ref_o), 0);
    check("R3 droop cleared", int'(droop_o), 0);
    pulse(QUAL + 1);
    check("R2 no ref when off", int'(ref_o), 0);

    repeat (4) @(negedge clk);
    done = 1;
    check("R4 all strobes seen", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule